// File: doc/BRIEF.md
# Sectored Write-Back Two-Way Data Cache

This block is a small data cache between a CPU port and a slower memory port, covering a byte-addressed 8-bit address space. It is organised as four sets of two ways. Every 8-byte line is made of two 4-byte sectors, and each sector has its own valid and dirty flags. The CPU issues single-sector reads and full-sector writes through a valid/ready handshake. The memory side moves exactly one sector per request/acknowledge transaction.

Because state is kept per sector, the memory port carries less traffic than a line-based design:
- A full-sector write miss takes over the line without reading memory.
- A read miss fetches only the missing sector.
- An eviction writes back only the sectors that were modified.

Victim selection prefers an empty way. Otherwise it uses one least-recently-used bit per set.

The controller is a five-state machine:
- **LOOK**: idle and lookup.
- **WBACK**: drain the dirty sectors of the victim.
- **CLAIM**: clear the victim's flags and install the new tag.
- **FILL**: fetch one sector.
- **ALLOC**: mark a written sector valid.

The transitions are:
- LOOK→FILL: read sector miss on a matching line.
- LOOK→ALLOC: write sector miss on a matching line.
- LOOK→WBACK: tag miss with a dirty victim.
- LOOK→CLAIM: tag miss with a clean victim.
- WBACK→WBACK: another dirty sector remains.
- WBACK→CLAIM: no dirty sector remains.
- CLAIM→FILL for a read, CLAIM→ALLOC for a write.
- FILL→LOOK on acknowledge.
- ALLOC→LOOK.

Back in LOOK, the held request now hits and completes.

Top module: `sect_cache`

## Requirements
- R1: The address splits as tag = bits 7:5, set = bits 4:3, sector = bit 2, byte = bits 1:0. A request whose set holds a valid sector under a matching tag completes with `cpu_ready` high in the same cycle as `cpu_valid`, `cpu_hit` high, and `cpu_rdata` set to the stored sector.
- R2: Reset clears every valid, dirty and LRU bit and both counters, so the first access to any address misses.
- R3: A read miss issues exactly one memory read, with `mem_we`=0, at the sector address {tag,set,sector,2'b00}. The other sector of the line is kept.
- R4: A CPU write never causes memory traffic by itself. Modified data reaches memory only when its line is evicted.
- R5: A write miss allocates the line, or the sector of a matching line, without any memory read. The written sector becomes valid and dirty.
- R6: On a tag miss the victim is way 0 if it has no valid sector, otherwise way 1 if it has none. If both hold valid sectors, the victim is the way named by the set's LRU bit.
- R7: After each completed access the set's LRU bit names the other way. A miss leaves it unchanged until the access completes.
- R8: Before a victim is reused, each of its dirty sectors is written back as a separate transaction with `mem_we`=1, lowest sector first, at {old tag,set,sector,2'b00}. Clean sectors are not written. All of the victim's flags are then cleared.
- R9: `cpu_ready` stays low from the detection of a miss until the fill or allocation is done. The access then completes with `cpu_hit` low. `cpu_ready` is never high without `cpu_valid`, nor while `mem_req` is high.
- R10: `hit_count` rises by one for each access that hits on first lookup. `miss_count` rises by one for each access that misses, however many memory transactions follow.
- R11: `mem_req` is held, with a stable address and direction, until `mem_ack`. Each `mem_ack` cycle ends exactly one transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request present; hold until ready |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_we | input | 1 | 1 = full-sector write, 0 = read |
| cpu_addr | input | 8 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_hit | output | 1 | Completing access hit on first lookup |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_addr | output | 8 | Sector byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Fetch data, valid with mem_ack |
| mem_ack | input | 1 | Transaction done |
| hit_count | output | 16 | Count of first-lookup hits |
| miss_count | output | 16 | Count of missed accesses |

## Verification
The bench builds the cache with its default parameters: a 3-bit tag, four sets, two sectors of 32 bits, 16-bit counters, and a memory that answers after two wait cycles. The space is this small, so a random mix over four tags quickly forces tag conflicts in every set. It also produces two-dirty-sector evictions, sector misses on resident lines, and allocation into empty ways. The directed opening walks each of these cases in a known order, so the LRU and victim choices can be traced by hand.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int WAYS = 2;

    typedef enum logic [2:0] {
        ST_LOOK,
        ST_WBACK,
        ST_CLAIM,
        ST_FILL,
        ST_ALLOC
    } sc_state_e;
endpackage

// File: rtl/sc_pick.sv
// Lowest-set-bit finder, used to order the write-back of dirty sectors.
module sc_pick #(
    parameter int N = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     bits_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits_i[i]) idx_o = IDX_W'(i);
        end
    end
    assign any_o = |bits_i;
endmodule

// File: rtl/sc_tag_store.sv
// Per-set, per-way tag plus per-sector valid/dirty flags and one LRU bit per set.
module sc_tag_store #(
    parameter int TAG_W = 3,
    parameter int SET_W = 2,
    parameter int SEC_W = 1,
    localparam int SETS = 1 << SET_W,
    localparam int SECS = 1 << SEC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_W-1:0]           set_i,
    input  logic                       way_i,
    input  logic [SEC_W-1:0]           sec_i,
    input  logic                       claim_i,
    input  logic [TAG_W-1:0]           tag_i,
    input  logic                       set_vld_i,
    input  logic                       set_drt_i,
    input  logic                       clr_drt_i,
    input  logic [SEC_W-1:0]           clr_sec_i,
    input  logic                       touch_i,
    output logic [1:0][TAG_W-1:0]      tag_o,
    output logic [1:0][SECS-1:0]       vld_o,
    output logic [1:0][SECS-1:0]       drt_o,
    output logic                       lru_o
);
    logic [TAG_W-1:0] tag_q [SETS][2];
    logic [SECS-1:0]  vld_q [SETS][2];
    logic [SECS-1:0]  drt_q [SETS][2];
    logic [SETS-1:0]  lru_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < 2; w++) begin
                    tag_q[s][w] <= '0;
                    vld_q[s][w] <= '0;
                    drt_q[s][w] <= '0;
                end
            end
            lru_q <= '0;
        end else begin
            if (claim_i) begin
                tag_q[set_i][way_i] <= tag_i;
                vld_q[set_i][way_i] <= '0;
                drt_q[set_i][way_i] <= '0;
            end
            if (set_vld_i) vld_q[set_i][way_i][sec_i] <= 1'b1;
            if (set_drt_i) drt_q[set_i][way_i][sec_i] <= 1'b1;
            if (clr_drt_i) drt_q[set_i][way_i][clr_sec_i] <= 1'b0;
            if (touch_i)   lru_q[set_i] <= ~way_i;
        end
    end

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign tag_o[w] = tag_q[set_i][w];
        assign vld_o[w] = vld_q[set_i][w];
        assign drt_o[w] = drt_q[set_i][w];
    end
    assign lru_o = lru_q[set_i];
endmodule

// File: rtl/sc_data_store.sv
// Sector data array: port A reads both ways of one sector, port B one way's chosen sector.
module sc_data_store #(
    parameter int SET_W  = 2,
    parameter int SEC_W  = 1,
    parameter int DATA_W = 32,
    localparam int IDX_W = SET_W + 1 + SEC_W,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                    clk,
    input  logic [SET_W-1:0]        set_i,
    input  logic                    we_i,
    input  logic                    wway_i,
    input  logic [SEC_W-1:0]        wsec_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [SEC_W-1:0]        sec_a_i,
    output logic [1:0][DATA_W-1:0]  rd_a_o,
    input  logic                    way_b_i,
    input  logic [SEC_W-1:0]        sec_b_i,
    output logic [DATA_W-1:0]       rd_b_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[{set_i, wway_i, wsec_i}] <= wdata_i;
    end

    for (genvar w = 0; w < 2; w++) begin : g_rd
        assign rd_a_o[w] = mem_q[{set_i, 1'(w), sec_a_i}];
    end
    assign rd_b_o = mem_q[{set_i, way_b_i, sec_b_i}];
endmodule

// File: rtl/sect_cache.sv
module sect_cache
    import sc_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int SET_W  = 2,
    parameter int SEC_W  = 1,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int ADDR_W = TAG_W + SET_W + SEC_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int SECS = 1 << SEC_W;

    // address fields
    logic [TAG_W-1:0] a_tag;
    logic [SET_W-1:0] a_set;
    logic [SEC_W-1:0] a_sec;
    logic             unused_byte;
    assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_set = cpu_addr[BYTE_W+SEC_W +: SET_W];
    assign a_sec = cpu_addr[BYTE_W +: SEC_W];
    assign unused_byte = ^cpu_addr[BYTE_W-1:0];

    sc_state_e state, nxt;
    logic      tgt_way, missed_q;

    // tag store wires
    logic [1:0][TAG_W-1:0] tag_v;
    logic [1:0][SECS-1:0]  vld_v, drt_v;
    logic                  lru_b;
    logic                  ts_way, ts_claim, ts_vld, ts_drt, ts_clr, ts_touch;

    // data store wires
    logic [1:0][DATA_W-1:0] rd_a;
    logic [DATA_W-1:0]      rd_b, ds_wdata;
    logic                   ds_we;

    // lookup
    logic [1:0] match, sec_hit, busy;
    logic       lookup_hit, hit_way, match_any, match_way, victim;
    logic       dirty_any, miss_event;
    logic [SEC_W-1:0] dsec;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign busy[w]    = |vld_v[w];
        assign match[w]   = busy[w] && (tag_v[w] == a_tag);
        assign sec_hit[w] = match[w] && vld_v[w][a_sec];
    end
    assign lookup_hit = |sec_hit;
    assign hit_way    = sec_hit[1];
    assign match_any  = |match;
    assign match_way  = match[1];
    assign victim     = !busy[0] ? 1'b0 : (!busy[1] ? 1'b1 : lru_b);
    assign miss_event = (state == ST_LOOK) && cpu_valid && !lookup_hit;

    sc_tag_store #(.TAG_W(TAG_W), .SET_W(SET_W), .SEC_W(SEC_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .set_i(a_set), .way_i(ts_way), .sec_i(a_sec),
        .claim_i(ts_claim), .tag_i(a_tag), .set_vld_i(ts_vld), .set_drt_i(ts_drt),
        .clr_drt_i(ts_clr), .clr_sec_i(dsec), .touch_i(ts_touch),
        .tag_o(tag_v), .vld_o(vld_v), .drt_o(drt_v), .lru_o(lru_b)
    );

    sc_data_store #(.SET_W(SET_W), .SEC_W(SEC_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .set_i(a_set), .we_i(ds_we), .wway_i(ts_way), .wsec_i(a_sec),
        .wdata_i(ds_wdata), .sec_a_i(a_sec), .rd_a_o(rd_a),
        .way_b_i(tgt_way), .sec_b_i(dsec), .rd_b_o(rd_b)
    );

    sc_pick #(.N(SECS)) u_dpick (
        .bits_i(drt_v[tgt_way]), .any_o(dirty_any), .idx_o(dsec)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOOK;
        else        state <= nxt;
    end

    // miss bookkeeping and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_way    <= 1'b0;
            missed_q   <= 1'b0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (miss_event) begin
                tgt_way  <= match_any ? match_way : victim;
                missed_q <= 1'b1;
                if (!missed_q) miss_count <= miss_count + 1'b1;
            end
            if (cpu_ready) begin
                missed_q <= 1'b0;
                if (!missed_q) hit_count <= hit_count + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOOK: begin
                if (miss_event) begin
                    if (match_any)                nxt = cpu_we ? ST_ALLOC : ST_FILL;
                    else if (|drt_v[victim])      nxt = ST_WBACK;
                    else                          nxt = ST_CLAIM;
                end
            end
            ST_WBACK: if (!dirty_any) nxt = ST_CLAIM;
            ST_CLAIM: nxt = cpu_we ? ST_ALLOC : ST_FILL;
            ST_FILL:  if (mem_ack) nxt = ST_LOOK;
            ST_ALLOC: nxt = ST_LOOK;
            default:  nxt = ST_LOOK;
        endcase
    end

    // outputs and store controls
    always_comb begin
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {a_tag, a_set, a_sec, {BYTE_W{1'b0}}};
        ts_way    = tgt_way;
        ts_claim  = 1'b0;
        ts_vld    = 1'b0;
        ts_drt    = 1'b0;
        ts_clr    = 1'b0;
        ts_touch  = 1'b0;
        ds_we     = 1'b0;
        ds_wdata  = cpu_wdata;
        unique case (state)
            ST_LOOK: begin
                ts_way    = hit_way;
                cpu_ready = cpu_valid && lookup_hit;
                ts_touch  = cpu_ready;
                ds_we     = cpu_ready && cpu_we;
                ts_drt    = cpu_ready && cpu_we;
            end
            ST_WBACK: begin
                mem_req  = dirty_any;
                mem_we   = 1'b1;
                mem_addr = {tag_v[tgt_way], a_set, dsec, {BYTE_W{1'b0}}};
                ts_clr   = dirty_any && mem_ack;
            end
            ST_CLAIM: ts_claim = 1'b1;
            ST_FILL: begin
                mem_req  = 1'b1;
                ds_wdata = mem_rdata;
                ds_we    = mem_ack;
                ts_vld   = mem_ack;
            end
            ST_ALLOC: ts_vld = 1'b1;
            default: ;
        endcase
    end

    assign mem_wdata = rd_b;
    assign cpu_rdata = rd_a[hit_way];
    assign cpu_hit   = cpu_ready && !missed_q;
endmodule

// File: rtl/sc_checks.sv
module sc_checks #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_hit,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid);

    a_r9_no_ready_in_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    a_r9_hit_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> cpu_ready);

    a_r11_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r8_wb_same_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[4:3] == cpu_addr[4:3]));

    a_r4_write_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |=> !mem_req);

    a_r10_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + 1'b1)));

    a_r10_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_hit |=> $stable(hit_count));
endmodule

bind sect_cache sc_checks #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_sc_checks (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_hit(cpu_hit), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/test_sect_cache.sv
`timescale 1ns/1ps
module test_sect_cache;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_hit;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] hit_count, miss_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    sect_cache i_sect_cache (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int checks = 0, errors = 0, cycles = 0, lat = 0;

    // reference model: plain arrays
    logic [2:0]  m_tag [4][2];
    bit          m_v   [4][2][2];
    bit          m_d   [4][2][2];
    logic [31:0] m_dat [4][2][2];
    bit          m_lru [4];
    logic [31:0] gold  [64];
    logic [31:0] bmem  [64];
    int          m_hits = 0, m_miss = 0;
    logic [40:0] exq [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(1'b0, "R9", "watchdog cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    // memory responder, driven on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; lat = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0; lat = 0;
        end else if (mem_req) begin
            if (lat == MEM_LAT) begin
                mem_ack = 1'b1; lat = 0;
                if (exq.size() == 0) begin
                    check(1'b0, "R11", "unexpected memory request addr", {24'h0, mem_addr}, 32'h0);
                end else begin
                    logic [40:0] e;
                    string r;
                    e = exq.pop_front();
                    r = e[40] ? "R8" : "R3";
                    check(mem_we == e[40], r, "memory direction", {31'h0, mem_we}, {31'h0, e[40]});
                    check(mem_addr == e[39:32], r, "memory address", {24'h0, mem_addr}, {24'h0, e[39:32]});
                    if (e[40]) check(mem_wdata == e[31:0], "R8", "write-back data", mem_wdata, e[31:0]);
                end
                if (mem_we) bmem[mem_addr[7:2]] = mem_wdata;
                else        mem_rdata = bmem[mem_addr[7:2]];
            end else begin
                lat++;
            end
        end else begin
            lat = 0;
        end
    end

    task automatic access(input bit we, input logic [2:0] t, input logic [1:0] s,
                          input bit sc, input logic [31:0] wd, input string req);
        logic [7:0]  addr;
        logic [31:0] e_rd;
        bit          e_hit, any0, any1;
        int          hw, mw, vic, waited;
        addr = {t, s, sc, 2'b00};
        hw = -1; mw = -1;
        for (int w = 0; w < 2; w++)
            if ((m_v[s][w][0] || m_v[s][w][1]) && m_tag[s][w] == t) mw = w;
        if (mw >= 0 && m_v[s][mw][sc]) hw = mw;
        if (hw >= 0) begin
            e_hit = 1'b1; m_hits++;
        end else begin
            e_hit = 1'b0; m_miss++;
            if (mw < 0) begin
                any0 = m_v[s][0][0] || m_v[s][0][1];
                any1 = m_v[s][1][0] || m_v[s][1][1];
                vic = !any0 ? 0 : (!any1 ? 1 : int'(m_lru[s]));
                for (int k = 0; k < 2; k++) begin
                    if (m_d[s][vic][k]) begin
                        logic [7:0] wa;
                        wa = {m_tag[s][vic], s, k[0], 2'b00};
                        exq.push_back({1'b1, wa, m_dat[s][vic][k]});
                        gold[wa[7:2]] = m_dat[s][vic][k];
                    end
                    m_v[s][vic][k] = 1'b0;
                    m_d[s][vic][k] = 1'b0;
                end
                m_tag[s][vic] = t;
                mw = vic;
            end
            if (!we) begin
                exq.push_back({1'b0, addr, gold[addr[7:2]]});
                m_dat[s][mw][sc] = gold[addr[7:2]];
            end
            m_v[s][mw][sc] = 1'b1;
            hw = mw;
        end
        if (we) begin
            m_dat[s][hw][sc] = wd;
            m_d[s][hw][sc] = 1'b1;
        end
        e_rd = m_dat[s][hw][sc];
        m_lru[s] = (hw == 0);

        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        #1;
        waited = 0;
        while (!cpu_ready) begin
            @(negedge clk); #1; waited++;
        end
        check(cpu_hit == e_hit, req, "hit flag", {31'h0, cpu_hit}, {31'h0, e_hit});
        if (e_hit) check(waited == 0, "R1", "hit wait cycles", waited, 0);
        else       check(waited > 0, "R9", "miss wait cycles nonzero", waited, 1);
        if (!we) check(cpu_rdata == e_rd, req, "read data", cpu_rdata, e_rd);
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        #1;
        check(hit_count == 16'(m_hits), "R10", "hit count", {16'h0, hit_count}, m_hits);
        check(miss_count == 16'(m_miss), "R10", "miss count", {16'h0, miss_count}, m_miss);
        check(exq.size() == 0, req, "pending memory transactions", exq.size(), 0);
        exq.delete();
    endtask

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < 64; i++) begin
            bmem[i] = 32'h1000_0000 + i * 32'h0001_0203;
            gold[i] = bmem[i];
        end
        for (int s = 0; s < 4; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_tag[s][w] = '0;
                for (int k = 0; k < 2; k++) begin
                    m_v[s][w][k] = 1'b0; m_d[s][w][k] = 1'b0; m_dat[s][w][k] = '0;
                end
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(cpu_ready == 1'b0, "R2", "ready after reset", {31'h0, cpu_ready}, 0);
        check(mem_req == 1'b0, "R2", "mem_req after reset", {31'h0, mem_req}, 0);
        check(hit_count == 0 && miss_count == 0, "R2", "counters after reset",
              {hit_count, miss_count}, 0);

        access(1'b0, 3'd1, 2'd0, 1'b0, 32'h0, "R2");          // compulsory read miss
        access(1'b0, 3'd1, 2'd0, 1'b0, 32'h0, "R1");          // read hit
        access(1'b0, 3'd1, 2'd0, 1'b1, 32'h0, "R3");          // sector miss, one fetch
        access(1'b0, 3'd1, 2'd0, 1'b0, 32'h0, "R3");          // first sector kept
        access(1'b1, 3'd1, 2'd0, 1'b0, 32'hCAFE_0001, "R4");  // write hit, no traffic
        access(1'b1, 3'd2, 2'd0, 1'b1, 32'hBEEF_0002, "R5");  // write miss into empty way 1
        access(1'b0, 3'd2, 2'd0, 1'b1, 32'h0, "R5");          // read back allocated sector
        access(1'b0, 3'd3, 2'd0, 1'b0, 32'h0, "R6");          // evict LRU way 0, one dirty sector
        access(1'b0, 3'd1, 2'd0, 1'b0, 32'h0, "R7");          // evicted data came back
        access(1'b1, 3'd4, 2'd1, 1'b1, 32'h1111_0001, "R5");
        access(1'b1, 3'd4, 2'd1, 1'b0, 32'h1111_0000, "R5");  // sector write miss on match
        access(1'b0, 3'd5, 2'd1, 1'b0, 32'h0, "R6");          // way 1 empty
        access(1'b0, 3'd6, 2'd1, 1'b1, 32'h0, "R8");          // two dirty sectors, lowest first
        access(1'b0, 3'd4, 2'd1, 1'b1, 32'h0, "R8");
        access(1'b0, 3'd4, 2'd1, 1'b0, 32'h0, "R7");

        lcg = 32'h1234_5678;
        for (int n = 0; n < 120; n++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            access(lcg[20], {1'b0, lcg[17:16]}, lcg[19:18], lcg[22], lcg ^ 32'h5A5A_0000, "R11");
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule